// File: doc/BRIEF.md
# Waveform Sample Decimator and Byte Reader

This block sits beside the path that carries a 20-bit, two's-complement sample stream toward the power computation. The stream goes on to that path untouched and with no added delay. When waveform capture is switched on, the block also forwards a subset of the samples to a host. It keeps every sample, every second, every fourth or every eighth, as set by a 2-bit rate select.

Each forwarded sample is sign-extended to 24 bits and latched in a holding register. An active-low interrupt then announces that the sample is ready. The host reads the word as three bytes, most significant byte first. It takes each byte from `rd_data` and pulses `rd_stb` to move on to the next one.

Capture is switched on by two controls together: a 2-bit mode field that must hold the waveform code, and an interrupt-enable bit. If a new sample is forwarded before the previous one has been read out completely, the new sample replaces the old one and a sticky overrun flag is raised.

Top module: `smp_tap`

## Requirements
- R1: Capture is on only while `mode_sel` equals 2'b10 and `irq_en` is 1. While capture is off, `irq_n` is high the following cycle, no sample is forwarded, the pending read is dropped and `ovr` is cleared.
- R2: With rate select r (0..3), the block forwards the first valid input sample after capture turns on or after any configuration change. After that it forwards every 2^r-th valid input sample.
- R3: `irq_n` falls in the cycle after the input cycle of a forwarded sample. It stays low until the first `rd_stb` of that sample, and returns high in the cycle after that strobe.
- R4: The held word is the forwarded 20-bit sample sign-extended to 24 bits: bits 23:20 copy bit 19.
- R5: After a forward, `rd_data` shows held bits 23:16. Each `rd_stb` while a read is pending advances it to bits 15:8 and then to bits 7:0. The third strobe ends the read and returns the pointer to bits 23:16. A strobe with no read pending changes nothing.
- R6: Valid input samples that are not forwarded leave the held word and the byte pointer unchanged, even in the middle of a read.
- R7: A forward that arrives while fewer than three bytes of the previous sample have been read overwrites the held word and restarts at bits 23:16. It also sets `ovr`, which stays set until capture is switched off.
- R8: Any change of `rate_sel`, `mode_sel` or the capture-on condition restarts the decimation count, so the next valid sample after the change is forwarded.
- R9: `pass_valid` and `pass_data` equal `in_valid` and `in_data` in the same cycle, whatever the capture state or read activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input sample strobe at the base rate |
| in_data | input | 20 | Signed input sample |
| mode_sel | input | 2 | Mode field; 2'b10 selects waveform capture |
| rate_sel | input | 2 | Decimation select: divide by 1, 2, 4 or 8 |
| irq_en | input | 1 | Waveform interrupt enable |
| rd_stb | input | 1 | Host byte acknowledge; advances to the next byte |
| rd_data | output | 8 | Current byte of the held word |
| irq_n | output | 1 | Active-low sample-ready interrupt |
| ovr | output | 1 | Sticky overrun flag |
| pass_valid | output | 1 | Sample strobe to the power path |
| pass_data | output | 20 | Sample to the power path |

## Verification
Samples are sent at all four rate selects with a full read after every forward, so that each divide ratio is told apart by which samples raise the interrupt. Positive, negative, most-positive and most-negative words separate correct sign extension from zero fill and from byte-order errors. Interleaving skipped samples with a partial read separates a latched word from a live one, and a second forward during a partial read exercises the overrun path. Configuration changes made part-way through a count show whether the counter restarts.

// File: rtl/smp_tap_pkg.sv
package smp_tap_pkg;

    typedef logic [1:0] mode_t;

    // mode field value that selects waveform capture
    localparam mode_t MODE_WAVE = 2'b10;

    localparam int unsigned BYTE_W = 8;

endpackage

// File: rtl/smp_tap_gate.sv
module smp_tap_gate
    import smp_tap_pkg::*;
#(
    parameter int unsigned RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mode_t             mode_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              irq_en,
    output logic              cap_en,
    output logic              cfg_hit
);

    typedef struct packed {
        mode_t             mode;
        logic [RATE_W-1:0] rate;
        logic              on;
    } gate_st_t;

    gate_st_t st_d, st_q;
    logic     on_now;

    always_comb begin
        on_now     = (mode_sel == MODE_WAVE) && irq_en;
        st_d.mode  = mode_sel;
        st_d.rate  = rate_sel;
        st_d.on    = on_now;
        cap_en     = on_now;
        cfg_hit    = (mode_sel != st_q.mode) || (rate_sel != st_q.rate) || (on_now != st_q.on);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smp_tap_decim.sv
module smp_tap_decim #(
    parameter int unsigned RATE_W = 2,
    parameter int unsigned CNT_W  = (1 << RATE_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              cap_en,
    input  logic              cfg_hit,
    input  logic [RATE_W-1:0] rate_sel,
    output logic              take
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } dec_st_t;

    dec_st_t          st_d, st_q;
    logic [CNT_W-1:0] reload;

    always_comb begin
        reload = (CNT_W'(1) << rate_sel) - CNT_W'(1);
        take   = in_valid && cap_en && !cfg_hit && (st_q.cnt == '0);
        st_d   = st_q;
        if (!cap_en || cfg_hit) begin
            st_d.cnt = '0;
        end else if (in_valid) begin
            if (take) begin
                st_d.cnt = reload;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smp_tap_hold.sv
module smp_tap_hold
    import smp_tap_pkg::*;
#(
    parameter int unsigned SMP_W  = 20,
    parameter int unsigned NBYTES = 3,
    parameter int unsigned WORD_W = NBYTES * BYTE_W,
    parameter int unsigned PTR_W  = $clog2(NBYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic              take,
    input  logic [SMP_W-1:0]  in_data,
    input  logic              rd_stb,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq_n,
    output logic              ovr,
    output logic              pend,
    output logic [WORD_W-1:0] word
);

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [PTR_W-1:0]  ptr;
        logic              pend;
        logic              irq;
        logic              ovr;
    } hold_st_t;

    hold_st_t          st_d, st_q;
    logic [BYTE_W-1:0] lane [NBYTES];
    logic [WORD_W-1:0] ext;

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_lane
        assign lane[gi] = st_q.word[WORD_W-1-BYTE_W*gi -: BYTE_W];
    end

    always_comb begin
        ext = {{(WORD_W-SMP_W){in_data[SMP_W-1]}}, in_data};
        st_d = st_q;
        if (!cap_en) begin
            st_d.ptr  = '0;
            st_d.pend = 1'b0;
            st_d.irq  = 1'b0;
            st_d.ovr  = 1'b0;
        end else if (take) begin
            st_d.word = ext;
            st_d.ptr  = '0;
            st_d.pend = 1'b1;
            st_d.irq  = 1'b1;
            if (st_q.pend) begin
                st_d.ovr = 1'b1;
            end
        end else if (rd_stb && st_q.pend) begin
            st_d.irq = 1'b0;
            if (st_q.ptr == PTR_W'(NBYTES - 1)) begin
                st_d.ptr  = '0;
                st_d.pend = 1'b0;
            end else begin
                st_d.ptr = st_q.ptr + PTR_W'(1);
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (st_q.ptr == PTR_W'(i)) begin
                rd_data = lane[i];
            end
        end
        irq_n = !st_q.irq;
        ovr   = st_q.ovr;
        pend  = st_q.pend;
        word  = st_q.word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/smp_tap.sv
module smp_tap
    import smp_tap_pkg::*;
#(
    parameter int unsigned SMP_W  = 20,
    parameter int unsigned NBYTES = 3,
    parameter int unsigned RATE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SMP_W-1:0]  in_data,
    input  logic [1:0]        mode_sel,
    input  logic [RATE_W-1:0] rate_sel,
    input  logic              irq_en,
    input  logic              rd_stb,
    output logic [7:0]        rd_data,
    output logic              irq_n,
    output logic              ovr,
    output logic              pass_valid,
    output logic [SMP_W-1:0]  pass_data
);

    localparam int unsigned CNT_W  = (1 << RATE_W) - 1;
    localparam int unsigned WORD_W = NBYTES * BYTE_W;

    logic              cap_en;
    logic              cfg_hit;
    logic              take;
    logic              pend;
    logic [WORD_W-1:0] hold_word;

    // power path: same-cycle pass-through, never gated by capture
    assign pass_valid = in_valid;
    assign pass_data  = in_data;

    smp_tap_gate #(
        .RATE_W (RATE_W)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .rate_sel (rate_sel),
        .irq_en   (irq_en),
        .cap_en   (cap_en),
        .cfg_hit  (cfg_hit)
    );

    smp_tap_decim #(
        .RATE_W (RATE_W),
        .CNT_W  (CNT_W)
    ) u_decim (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .cap_en   (cap_en),
        .cfg_hit  (cfg_hit),
        .rate_sel (rate_sel),
        .take     (take)
    );

    smp_tap_hold #(
        .SMP_W  (SMP_W),
        .NBYTES (NBYTES)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .take    (take),
        .in_data (in_data),
        .rd_stb  (rd_stb),
        .rd_data (rd_data),
        .irq_n   (irq_n),
        .ovr     (ovr),
        .pend    (pend),
        .word    (hold_word)
    );

endmodule

// File: rtl/smp_tap_chk.sv
module smp_tap_chk #(
    parameter int unsigned SMP_W  = 20,
    parameter int unsigned WORD_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cap_en,
    input logic              take,
    input logic              rd_stb,
    input logic              irq_n,
    input logic              ovr,
    input logic              pend,
    input logic [WORD_W-1:0] hold_word
);

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_en |=> irq_n); // R1

    AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(take)); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !irq_n && !take && cap_en) |=> irq_n); // R3

    AST_SIGN_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        pend |-> (hold_word[WORD_W-1:SMP_W] == {(WORD_W-SMP_W){hold_word[SMP_W-1]}})); // R4

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && cap_en) |=> ovr); // R7

    AST_OVR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $past(take && pend)); // R7

endmodule

bind smp_tap smp_tap_chk #(
    .SMP_W  (SMP_W),
    .WORD_W (NBYTES * 8)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cap_en    (cap_en),
    .take      (take),
    .rd_stb    (rd_stb),
    .irq_n     (irq_n),
    .ovr       (ovr),
    .pend      (pend),
    .hold_word (hold_word)
);

// File: tb/smp_tap_bench.sv
module smp_tap_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [19:0] in_data = '0;
    logic [1:0]  mode_sel = 2'b00;
    logic [1:0]  rate_sel = 2'b00;
    logic        irq_en = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;
    logic        irq_n;
    logic        ovr;
    logic        pass_valid;
    logic [19:0] pass_data;

    always #2.5 clk = ~clk;

    smp_tap u_smp_tap (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .mode_sel   (mode_sel),
        .rate_sel   (rate_sel),
        .irq_en     (irq_en),
        .rd_stb     (rd_stb),
        .rd_data    (rd_data),
        .irq_n      (irq_n),
        .ovr        (ovr),
        .pass_valid (pass_valid),
        .pass_data  (pass_data)
    );

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // scoreboard and reference model state
    logic [23:0] exp_q [$];
    logic [23:0] cur = '0;
    int  m_cnt = 0;
    bit  m_cap = 1'b0;
    int  m_rate = 0;
    bit  m_pend = 1'b0;
    bit  m_irq = 1'b0;
    bit  m_ovr = 1'b0;
    int  m_ptr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        check(irq_n == !m_irq, req, "irq_n", longint'(irq_n), longint'(!m_irq));
        check(ovr == m_ovr, req, "ovr", longint'(ovr), longint'(m_ovr));
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [1:0] r, input logic e);
        bit new_cap;
        @(negedge clk);
        new_cap = (m == 2'b10) && e;
        if (m != mode_sel || r != rate_sel || new_cap != m_cap) m_cnt = 0;
        mode_sel = m;
        rate_sel = r;
        irq_en   = e;
        m_cap    = new_cap;
        m_rate   = r;
        if (!new_cap) begin
            exp_q.delete();
            m_pend = 0; m_irq = 0; m_ovr = 0; m_ptr = 0;
        end
        @(negedge clk);
    endtask

    // driver: presents one sample and pushes the expected word when forwarded
    task automatic send(input logic [19:0] d, input string req);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        #0.5;
        check(pass_valid == 1'b1 && pass_data == d, "R9", "pass-through",
              longint'(pass_data), longint'(d));
        if (m_cap) begin
            if (m_cnt == 0) begin
                if (m_pend) m_ovr = 1;
                exp_q.delete();
                exp_q.push_back({{4{d[19]}}, d});
                m_pend = 1; m_irq = 1; m_ptr = 0;
                m_cnt = (1 << m_rate) - 1;
            end else begin
                m_cnt--;
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
        check_flags(req);
    endtask

    // monitor: reads one byte and compares with the scoreboard word
    task automatic read_byte(input string req);
        logic [7:0] want;
        @(negedge clk);
        if (m_ptr == 0) begin
            if (exp_q.size() == 0) begin
                check(1'b0, req, "scoreboard empty", 0, 1);
            end else begin
                cur = exp_q.pop_front();
            end
        end
        want = cur[23 - 8*m_ptr -: 8];
        check(rd_data == want, req, "rd_data", longint'(rd_data), longint'(want));
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        m_irq = 0;
        if (m_ptr == 2) begin
            m_ptr = 0; m_pend = 0;
        end else begin
            m_ptr++;
        end
        check_flags(req);
    endtask

    task automatic read_word(input string req);
        for (int i = 0; i < 3; i++) read_byte(req);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check(irq_n == 1'b1, "R1", "reset irq_n", longint'(irq_n), 1);
        check(ovr == 1'b0, "R1", "reset ovr", longint'(ovr), 0);

        // R1: capture off with wrong mode or enable low
        set_cfg(2'b01, 2'b00, 1'b1);
        send(20'h12345, "R1");
        send(20'h54321, "R1");
        set_cfg(2'b10, 2'b00, 1'b0);
        send(20'h11111, "R1");

        // R4/R5: full rate, sign extension and byte order
        set_cfg(2'b10, 2'b00, 1'b1);
        send(20'h2851F, "R4"); read_word("R5");
        send(20'hD7AE1, "R4"); read_word("R5");
        send(20'h7FFFF, "R4"); read_word("R5");
        send(20'h80000, "R4"); read_word("R4");
        // R5: strobe with nothing pending is ignored
        @(negedge clk); rd_stb = 1'b1; @(negedge clk); rd_stb = 1'b0;
        check(rd_data == cur[23:16], "R5", "idle strobe", longint'(rd_data), longint'(cur[23:16]));
        check_flags("R5");

        // R2: every divide ratio
        for (int r = 1; r < 4; r++) begin
            set_cfg(2'b10, 2'(r), 1'b1);
            for (int k = 0; k < 17; k++) begin
                send(20'(32'h0A000 + r * 256 + k * 7), "R2");
                if (m_pend) read_word("R2");
            end
        end

        // R6: skipped samples during a partial read
        set_cfg(2'b10, 2'b10, 1'b1);
        send(20'hC3852, "R6");
        read_byte("R6");
        send(20'h0BEEF, "R6");
        send(20'h0CAFE, "R6");
        read_byte("R6");
        send(20'h0F00D, "R6");
        read_byte("R6");

        // R7: overrun while a read is in progress
        set_cfg(2'b10, 2'b00, 1'b1);
        send(20'h1428F, "R7");
        read_byte("R7");
        send(20'hEBD71, "R7");
        read_word("R7");
        send(20'h3C7AE, "R7");
        read_word("R7");
        set_cfg(2'b00, 2'b00, 1'b1);
        check(ovr == 1'b0, "R7", "ovr cleared on disable", longint'(ovr), 0);

        // R8: counter restarts on rate change and on mode change
        set_cfg(2'b10, 2'b11, 1'b1);
        send(20'h00001, "R8"); read_word("R8");
        send(20'h00002, "R8");
        send(20'h00003, "R8");
        set_cfg(2'b10, 2'b10, 1'b1);
        send(20'h00004, "R8"); read_word("R8");
        send(20'h00005, "R8");
        set_cfg(2'b11, 2'b10, 1'b1);
        set_cfg(2'b10, 2'b10, 1'b1);
        send(20'hFFFFF, "R8"); read_word("R8");

        // R3: irq stays low until the first byte is read
        send(20'h00010, "R3");
        send(20'h00011, "R3");
        check_flags("R3");
        set_cfg(2'b10, 2'b00, 1'b1);
        send(20'h00020, "R3");
        repeat (3) @(negedge clk);
        check(irq_n == 1'b0, "R3", "irq held", longint'(irq_n), 0);
        read_word("R3");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule